// File: doc/BRIEF.md
# Thermal Trip Monitor

This block watches the temperature codes produced by up to three sensor channels and raises flags when a channel gets too hot. The codes run backwards: a hotter die gives a numerically smaller code. Each new code is compared with three programmable limits for its channel. The first is a hot limit that arms a warning. The second is a release limit that disarms the warning once the die has cooled. The third is a trip limit that asks for power-down.

Every event lands in a sticky status register that software clears by writing ones. A single interrupt line is the OR of every status bit that software has enabled. The enable bits sit at the same positions as the status bits, so one mask describes both registers.

Software programs the limits and enables through a simple register write/read port. The acquisition front end presents one valid strobe and one code per channel.

Top module: `thermal_trip_monitor`

## Requirements
- R1: After reset, all status bits, enables, limits and the period field read as zero, and `irqOut` is low.
- R2: The register map is as follows.
  - Offset 0x50+4k holds channel k's hot limit in bits [27:16] and its release limit in bits [11:0].
  - Offset 0x60+4k holds channel k's trip limit in bits [27:16].
  - Offset 0x44 holds the interrupt enables in bits 0-2, 4-6 and 8-10, and a period field in bits [31:12].
  - Offset 0x48 is the status register.
  - Bits that are not implemented read as zero.
- R3: Every valid code on channel k sets status bit 8+k (the new-data flag).
- R4: When channel k's warning is disarmed and a valid code is at or below the hot limit, the warning arms and status bit k is set.
- R5: Once armed, a warning stays armed until a valid code is strictly above the release limit. While it is armed, further hot codes do not set status bit k again. After release, the next hot code sets it again.
- R6: Every valid code on channel k that is at or below the trip limit sets status bit 4+k, on every such sample.
- R7: Writing a 1 to a status bit clears it, and writing a 0 leaves the bit unchanged. Writing back the value just read clears every pending flag.
- R8: If a status write clears a bit in the same cycle that an event sets it, the bit ends up set.
- R9: `irqOut` is high exactly when some status bit and its enable at the same position are both 1.
- R10: A code equal to a limit counts as reaching it. A code one above the hot limit or the trip limit does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational from `regAddr`) |
| sampleValid | input | 3 | Per-channel new-code strobe |
| sampleCode | input | 36 | Per-channel 12-bit codes, channel k at bits [12k+11:12k] |
| irqOut | output | 1 | Combined interrupt |

## Verification
The comparator is driven with codes just above, equal to and just below each limit. This shows that the test is inclusive and that the direction is inverted.

The hysteresis is tested by walking the code back and forth across the hot limit and the release limit. This separates an arm-once flag from one that fires on every hot sample, and a release taken at the limit from one taken strictly above it. The trip flag gets repeated hot samples to show that it fires every time.

Status writes are tried in several forms: partial masks, a full write-back, and a write that lands in the same cycle as a new event. These tell a correct write-one-to-clear apart from plain overwrites and from clears that win over events. The interrupt is checked with the enable mask matching and not matching the pending bits.

// File: rtl/thermcmp_pkg.sv
package thermcmp_pkg;
  localparam int STAT_W    = 11;
  localparam int ALARM_LSB = 0;
  localparam int SHUT_LSB  = 4;
  localparam int DATA_LSB  = 8;
  localparam int PER_LSB   = 12;

  localparam int INTC_OFS  = 'h44;
  localparam int STAT_OFS  = 'h48;
  localparam int ALARM_OFS = 'h50;
  localparam int SHUT_OFS  = 'h60;
  localparam int HOT_LSB   = 16;

  typedef struct packed {
    logic              clrWrite;
    logic [STAT_W-1:0] clrMask;
  } ctrl_strobe_t;

  function automatic logic [STAT_W-1:0] liveMask(int numCh);
    logic [STAT_W-1:0] m;
    m = '0;
    for (int k = 0; k < numCh; k++) begin
      m[ALARM_LSB+k] = 1'b1;
      m[SHUT_LSB+k]  = 1'b1;
      m[DATA_LSB+k]  = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/thermcmp_ctrl.sv
module thermcmp_ctrl
  import thermcmp_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CODE_W = 12,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           regWrEn,
  input  logic [ADDR_W-1:0]              regAddr,
  input  logic [DATA_W-1:0]              regWrData,
  output logic [DATA_W-1:0]              regRdData,
  input  logic [STAT_W-1:0]              statusIn,
  output logic [NUM_CH-1:0][CODE_W-1:0]  hotThr,
  output logic [NUM_CH-1:0][CODE_W-1:0]  hystThr,
  output logic [NUM_CH-1:0][CODE_W-1:0]  shutThr,
  output logic [STAT_W-1:0]              irqEnable,
  output ctrl_strobe_t                   strobe
);
  localparam int PER_W = DATA_W - PER_LSB;
  localparam logic [STAT_W-1:0] LIVE = liveMask(NUM_CH);

  logic [PER_W-1:0] periodReg;
  logic intcHit, statHit;

  assign intcHit = (regAddr == ADDR_W'(INTC_OFS));
  assign statHit = (regAddr == ADDR_W'(STAT_OFS));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      periodReg <= '0;
      irqEnable <= '0;
    end else if (regWrEn && intcHit) begin
      periodReg <= regWrData[DATA_W-1:PER_LSB];
      irqEnable <= regWrData[STAT_W-1:0] & LIVE;
    end
  end

  for (genvar k = 0; k < NUM_CH; k++) begin : g_chanRegs
    logic alarmHit, shutHit;
    assign alarmHit = (regAddr == ADDR_W'(ALARM_OFS + 4*k));
    assign shutHit  = (regAddr == ADDR_W'(SHUT_OFS + 4*k));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        hotThr[k]  <= '0;
        hystThr[k] <= '0;
        shutThr[k] <= '0;
      end else if (regWrEn) begin
        if (alarmHit) begin
          hotThr[k]  <= regWrData[HOT_LSB +: CODE_W];
          hystThr[k] <= regWrData[0 +: CODE_W];
        end
        if (shutHit) shutThr[k] <= regWrData[HOT_LSB +: CODE_W];
      end
    end
  end

  assign strobe.clrWrite = regWrEn && statHit;
  assign strobe.clrMask  = regWrData[STAT_W-1:0];

  always_comb begin
    regRdData = '0;
    if (intcHit) begin
      regRdData[DATA_W-1:PER_LSB] = periodReg;
      regRdData[STAT_W-1:0]       = irqEnable;
    end
    if (statHit) regRdData[STAT_W-1:0] = statusIn;
    for (int k = 0; k < NUM_CH; k++) begin
      if (regAddr == ADDR_W'(ALARM_OFS + 4*k)) begin
        regRdData[HOT_LSB +: CODE_W] = hotThr[k];
        regRdData[0 +: CODE_W]       = hystThr[k];
      end
      if (regAddr == ADDR_W'(SHUT_OFS + 4*k))
        regRdData[HOT_LSB +: CODE_W] = shutThr[k];
    end
  end

  // R2: enables never hold bits outside the live channel mask
  a_r2_enable_mask: assert property (@(posedge clk) disable iff (!rstN)
    (irqEnable & ~LIVE) == '0);
endmodule

// File: rtl/thermcmp_datapath.sv
module thermcmp_datapath
  import thermcmp_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CODE_W = 12
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_CH-1:0]              sampleValid,
  input  logic [NUM_CH-1:0][CODE_W-1:0]  sampleCode,
  input  logic [NUM_CH-1:0][CODE_W-1:0]  hotThr,
  input  logic [NUM_CH-1:0][CODE_W-1:0]  hystThr,
  input  logic [NUM_CH-1:0][CODE_W-1:0]  shutThr,
  input  logic [STAT_W-1:0]              irqEnable,
  input  ctrl_strobe_t                   strobe,
  output logic [STAT_W-1:0]              statusOut,
  output logic                           irqOut
);
  localparam logic [STAT_W-1:0] LIVE = liveMask(NUM_CH);

  logic [NUM_CH-1:0] alarmArmed, alarmSet, shutSet;
  logic [STAT_W-1:0] setVec, clrVec;

  for (genvar k = 0; k < NUM_CH; k++) begin : g_chan
    logic atHot, overHyst, atShut;
    assign atHot    = sampleCode[k] <= hotThr[k];
    assign overHyst = sampleCode[k] >  hystThr[k];
    assign atShut   = sampleCode[k] <= shutThr[k];
    assign alarmSet[k] = sampleValid[k] && !alarmArmed[k] && atHot;
    assign shutSet[k]  = sampleValid[k] && atShut;

    always_ff @(posedge clk) begin
      if (!rstN)                                   alarmArmed[k] <= 1'b0;
      else if (alarmSet[k])                        alarmArmed[k] <= 1'b1;
      else if (sampleValid[k] && alarmArmed[k] && overHyst) alarmArmed[k] <= 1'b0;
    end

    // R3: a valid sample always leaves its data flag set
    a_r3_data_flag: assert property (@(posedge clk) disable iff (!rstN)
      sampleValid[k] |=> statusOut[DATA_LSB+k]);
    // R6: a code at or below the trip limit leaves the trip flag set
    a_r6_trip_flag: assert property (@(posedge clk) disable iff (!rstN)
      (sampleValid[k] && sampleCode[k] <= shutThr[k]) |=> statusOut[SHUT_LSB+k]);
    // R5: an armed warning releases on a code above the release limit
    a_r5_release: assert property (@(posedge clk) disable iff (!rstN)
      (alarmArmed[k] && sampleValid[k] && sampleCode[k] > hystThr[k]
       && sampleCode[k] > hotThr[k]) |=> !alarmArmed[k]);
    // R7: a clear with no competing event drops the data flag
    a_r7_clear: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.clrWrite && strobe.clrMask[DATA_LSB+k] && !sampleValid[k])
      |=> !statusOut[DATA_LSB+k]);
  end

  always_comb begin
    setVec = '0;
    for (int k = 0; k < NUM_CH; k++) begin
      setVec[ALARM_LSB+k] = alarmSet[k];
      setVec[SHUT_LSB+k]  = shutSet[k];
      setVec[DATA_LSB+k]  = sampleValid[k];
    end
  end

  assign clrVec = strobe.clrWrite ? strobe.clrMask : '0;

  always_ff @(posedge clk) begin
    if (!rstN) statusOut <= '0;
    else       statusOut <= ((statusOut & ~clrVec) | setVec) & LIVE;
  end

  assign irqOut = |(statusOut & irqEnable);
endmodule

// File: rtl/thermal_trip_monitor.sv
module thermal_trip_monitor
  import thermcmp_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CODE_W = 12,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     regWrEn,
  input  logic [ADDR_W-1:0]        regAddr,
  input  logic [DATA_W-1:0]        regWrData,
  output logic [DATA_W-1:0]        regRdData,
  input  logic [NUM_CH-1:0]        sampleValid,
  input  logic [NUM_CH*CODE_W-1:0] sampleCode,
  output logic                     irqOut
);
  logic [NUM_CH-1:0][CODE_W-1:0] hotThr, hystThr, shutThr, codeVec;
  logic [STAT_W-1:0] irqEnable, statusBits;
  ctrl_strobe_t strobe;

  assign codeVec = sampleCode;

  thermcmp_ctrl #(.NUM_CH(NUM_CH), .CODE_W(CODE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .statusIn(statusBits),
    .hotThr(hotThr), .hystThr(hystThr), .shutThr(shutThr),
    .irqEnable(irqEnable), .strobe(strobe)
  );

  thermcmp_datapath #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) uDp (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleCode(codeVec),
    .hotThr(hotThr), .hystThr(hystThr), .shutThr(shutThr),
    .irqEnable(irqEnable), .strobe(strobe),
    .statusOut(statusBits), .irqOut(irqOut)
  );

  // R9: with every enable off the interrupt stays low
  a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (irqEnable == '0) |-> !irqOut);
endmodule

// File: tb/thermal_trip_monitor_test.sv
module thermal_trip_monitor_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [2:0]  sampleValid = '0;
  logic [35:0] sampleCode = '0;
  logic        irqOut;

  int testsRun = 0;
  int testsFailed = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  thermal_trip_monitor uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .sampleValid(sampleValid), .sampleCode(sampleCode), .irqOut(irqOut)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wrReg(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic feed(int ch, logic [11:0] code);
    @(negedge clk);
    sampleCode[ch*12 +: 12] = code;
    sampleValid[ch] = 1'b1;
    @(negedge clk);
    sampleValid = '0;
  endtask

  task automatic checkStat(string tag, logic [31:0] exp);
    logic [31:0] v;
    rdReg(8'h48, v);
    check(tag, v, exp);
  endtask

  task automatic clearAll();
    logic [31:0] v;
    rdReg(8'h48, v);
    wrReg(8'h48, v);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    checkStat("R1 status", 32'h0);
    rdReg(8'h44, v); check("R1 intctrl", v, 32'h0);
    rdReg(8'h54, v); check("R1 alarm1", v, 32'h0);
    check("R1 irq", {31'b0, irqOut}, 32'h0);
  endtask

  task automatic t_regmap();
    logic [31:0] v;
    wrReg(8'h50, 32'hFFFF_FFFF);
    rdReg(8'h50, v); check("R2 alarm0 fields", v, 32'h0FFF_0FFF);
    wrReg(8'h64, 32'hFFFF_FFFF);
    rdReg(8'h64, v); check("R2 shut1 field", v, 32'h0FFF_0000);
    wrReg(8'h44, 32'hFFFF_FFFF);
    rdReg(8'h44, v); check("R2 intctrl fields", v, 32'hFFFF_F777);
    wrReg(8'h44, 32'h0);
    wrReg(8'h50, 32'h0);
    wrReg(8'h64, 32'h0);
    wrReg(8'h48, 32'hFFFF_FFFF);
    checkStat("R7 ones on idle status", 32'h0);
  endtask

  task automatic t_data();
    feed(1, 12'h800);
    checkStat("R3 data flag ch1", 32'h200);
    clearAll();
    checkStat("R7 write-back clears", 32'h0);
  endtask

  task automatic t_alarm();
    wrReg(8'h50, 32'h0300_0380);
    feed(0, 12'h301);
    checkStat("R10 hot+1 no alarm", 32'h100);
    feed(0, 12'h300);
    checkStat("R4 R10 alarm at limit", 32'h101);
    clearAll();
  endtask

  task automatic t_hyst();
    feed(0, 12'h250);
    checkStat("R5 no refire while armed", 32'h100);
    feed(0, 12'h380);
    feed(0, 12'h300);
    checkStat("R5 at release limit stays armed", 32'h100);
    clearAll();
    feed(0, 12'h381);
    feed(0, 12'h300);
    checkStat("R5 rearm after release", 32'h101);
    clearAll();
  endtask

  task automatic t_shut();
    wrReg(8'h68, 32'h0400_0000);
    feed(2, 12'h401);
    checkStat("R10 trip+1 no trip", 32'h400);
    clearAll();
    feed(2, 12'h400);
    checkStat("R6 trip at limit", 32'h440);
    clearAll();
    feed(2, 12'h3FF);
    checkStat("R6 trip repeats", 32'h440);
    wrReg(8'h48, 32'h040);
    checkStat("R7 partial clear", 32'h400);
    wrReg(8'h48, 32'h400);
    checkStat("R7 second clear", 32'h0);
  endtask

  task automatic t_collide();
    @(negedge clk);
    sampleCode[12 +: 12] = 12'h800;
    sampleValid[1] = 1'b1;
    regAddr = 8'h48; regWrData = 32'h200; regWrEn = 1'b1;
    @(negedge clk);
    sampleValid = '0; regWrEn = 1'b0;
    checkStat("R8 set beats clear", 32'h200);
    clearAll();
  endtask

  task automatic t_irq();
    feed(0, 12'hFFF);
    #1 check("R9 irq masked", {31'b0, irqOut}, 32'h0);
    wrReg(8'h44, 32'h100);
    #1 check("R9 irq enabled", {31'b0, irqOut}, 32'h1);
    wrReg(8'h44, 32'h001);
    #1 check("R9 other enable", {31'b0, irqOut}, 32'h0);
    wrReg(8'h44, 32'h100);
    clearAll();
    @(negedge clk);
    #1 check("R9 irq after clear", {31'b0, irqOut}, 32'h0);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_regmap();
    t_data();
    t_alarm();
    t_hyst();
    t_shut();
    t_collide();
    t_irq();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule